// File: doc/BRIEF.md
# Saturating Arithmetic Unit

A 32-bit arithmetic unit whose results clamp to the limits of their number range instead of wrapping. An opcode picks one of several operations. Signed add, signed subtract and signed doubling clamp to the largest or smallest two's-complement word. Unsigned add clamps to all ones and unsigned subtract clamps to zero. A further group of operations limits a value to a signed or unsigned range whose width is set by a 5-bit input, either on the whole word or on each 16-bit half on its own.

The result of the operation presented in one cycle is registered and appears on `result` after the next rising clock edge. Every operation that has to clamp sets one shared sticky flag. The flag stays set until the dedicated clear input or reset removes it. This lets a sequence of operations be checked for any loss of range with a single test at the end.

Top module: `sat_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state has `result` = 0 and `sat_flag` = 0.
- R2: Opcode 1 (signed add). The operation overflows when both operands have the same sign and the sum has the other sign. On overflow the result is 0x7FFFFFFF if `opnd_a` is non-negative and 0x80000000 if it is negative. Otherwise the result is the wrapped sum. Like every operation, the result appears one clock edge after the inputs are sampled.
- R3: Opcode 2 (signed subtract `opnd_a - opnd_b`). The operation overflows when the operands differ in sign and the difference differs in sign from `opnd_a`. It clamps to the same two values as R2, chosen by the sign of `opnd_a`.
- R4: Opcode 3 (signed doubling of `opnd_a`). An input of at least 0x40000000 gives 0x7FFFFFFF. A signed input of at most 0xC0000000 gives 0x80000000; this includes 0xC0000000 itself, which counts as saturating. Any other input gives `opnd_a` shifted left by one.
- R5: Opcode 4 (unsigned add). A sum that carries out of 32 bits gives 0xFFFFFFFF.
- R6: Opcode 5 (unsigned subtract). When `opnd_b` is greater than `opnd_a`, the result is 0.
- R7: Opcode 6 (signed clamp of `opnd_a` to width n = `sat_width`). Values above 2^n-1 give 2^n-1, values below -2^n give -2^n, and other values pass through unchanged. This holds for every n from 0 to 31.
- R8: Opcode 7 (unsigned clamp to width n). A negative `opnd_a` gives 0, a value above 2^n-1 gives 2^n-1, and other values pass through unchanged.
- R9: Opcodes 8 (signed) and 9 (unsigned) apply the R7 and R8 clamps to bits 15:0 and bits 31:16 of `opnd_a` separately. Each half is treated as a sign-extended 16-bit value, and the low 16 bits of each clamped half go back into the same half of the result.
- R10: Any operation that clamps sets `sat_flag` at the edge that registers its result. An operation that does not clamp leaves `sat_flag` unchanged.
- R11: `flag_clr` high at an edge clears `sat_flag`. If an operation sampled at the same edge clamps, the flag is set instead.
- R12: Opcode 0 and opcodes 10 to 15 give `result` = 0 and never set `sat_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 4 | Operation select (see R2 to R12) |
| opnd_a | input | 32 | First operand; the only operand used by doubling and clamping |
| opnd_b | input | 32 | Second operand for add and subtract |
| sat_width | input | 5 | Range width n for the clamp operations |
| flag_clr | input | 1 | Clears the sticky flag |
| result | output | 32 | Registered result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Two events can land in the same cycle: a flag clear and an operation that clamps. The bench provokes this by raising `flag_clr` together with an overflowing signed add. It then expects the flag to read set one edge later. It repeats the clear with an operation that does not clamp and expects the flag to read clear. Between these cases, reference arithmetic runs at 64 bits and sweeps every clamp width from 0 to 31.

// File: rtl/sat_pkg.sv
// Package: shared opcode encoding for the saturating arithmetic unit.
// Assumes a 4-bit opcode; codes not listed are treated as no operation.
package sat_pkg;

    typedef enum logic [3:0] {
        OP_NONE    = 4'd0,
        OP_SADD    = 4'd1,
        OP_SSUB    = 4'd2,
        OP_SDBL    = 4'd3,
        OP_UADD    = 4'd4,
        OP_USUB    = 4'd5,
        OP_SCLAMP  = 4'd6,
        OP_UCLAMP  = 4'd7,
        OP_SCLAMP2 = 4'd8,
        OP_UCLAMP2 = 4'd9
    } sat_op_e;

endpackage

// File: rtl/sat_arith.sv
// Module: sat_arith
// Combinational saturating add, subtract and doubling on W-bit words.
// Assumes W >= 3. Produces a zero result and no saturation for any
// opcode it does not handle.
module sat_arith
    import sat_pkg::*;
#(
    parameter int W = 32
) (
    input  sat_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic           sat
);

    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   usum;
    logic [W:0]   udiff;
    logic [W-1:0] sclamp;
    logic         dbl_hi;
    logic         dbl_lo;

    // Wide sum and difference expose the carry and the borrow.
    always_comb begin
        usum   = {1'b0, a} + {1'b0, b};
        udiff  = {1'b0, a} - {1'b0, b};
        sclamp = a[W-1] ? SMIN : SMAX;
        dbl_hi = !a[W-1] && a[W-2];
        dbl_lo = a[W-1] && (!a[W-2] || (a[W-3:0] == '0));
    end

    // Select the operation and apply its clamp rule.
    always_comb begin
        res = '0;
        sat = 1'b0;
        unique case (op)
            OP_SADD: begin
                sat = (a[W-1] == b[W-1]) && (usum[W-1] != a[W-1]);
                res = sat ? sclamp : usum[W-1:0];
            end
            OP_SSUB: begin
                sat = (a[W-1] != b[W-1]) && (udiff[W-1] != a[W-1]);
                res = sat ? sclamp : udiff[W-1:0];
            end
            OP_SDBL: begin
                sat = dbl_hi || dbl_lo;
                if (dbl_hi)      res = SMAX;
                else if (dbl_lo) res = SMIN;
                else             res = {a[W-2:0], 1'b0};
            end
            OP_UADD: begin
                sat = usum[W];
                res = sat ? {W{1'b1}} : usum[W-1:0];
            end
            OP_USUB: begin
                sat = udiff[W];
                res = sat ? '0 : udiff[W-1:0];
            end
            default: begin
                res = '0;
                sat = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sat_clamp.sv
// Module: sat_clamp
// Combinational clamp of a signed W-bit value to a signed range
// [-2^n, 2^n-1] or an unsigned range [0, 2^n-1].
// Assumes n may reach or exceed W; the range then covers every input.
module sat_clamp #(
    parameter int W  = 32,
    parameter int NW = 5
) (
    input  logic [W-1:0]  val,
    input  logic [NW-1:0] n,
    input  logic          is_signed,
    output logic [W-1:0]  res,
    output logic          sat
);

    logic        [W-1:0] mask;
    logic signed [W-1:0] shr;
    logic                s_hi;
    logic                s_lo;
    logic                u_lo;
    logic                u_hi;

    // Range limit and the bits above the range.
    always_comb begin
        mask = (W'(1) << n) - W'(1);
        shr  = $signed(val) >>> n;
        s_hi = !shr[W-1] && (shr != '0);
        s_lo = shr[W-1] && (shr != '1);
        u_lo = val[W-1];
        u_hi = !val[W-1] && (val > mask);
    end

    // Pick the clamped value and flag.
    always_comb begin
        if (is_signed) begin
            sat = s_hi || s_lo;
            if (s_hi)      res = mask;
            else if (s_lo) res = ~mask;
            else           res = val;
        end else begin
            sat = u_lo || u_hi;
            if (u_lo)      res = '0;
            else if (u_hi) res = mask;
            else           res = val;
        end
    end

endmodule

// File: rtl/sat_sticky.sv
// Module: sat_sticky
// Sticky saturation flag. A set in the same cycle as a clear wins.
// Assumes synchronous active-low reset.
module sat_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    // Hold, clear or set the flag at each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= (flag && !clr) || set;
    end

    a_r10_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);

    a_r10_hold_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    a_r11_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);

endmodule

// File: rtl/sat_unit.sv
// Module: sat_unit (top)
// Saturating arithmetic unit: word add/sub/double, word clamp and
// dual-halfword clamp to a programmable width, with a registered result
// and a sticky saturation flag. Assumes DATA_W is even and at least 4.
module sat_unit
    import sat_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [3:0]                op_code,
    input  logic [DATA_W-1:0]         opnd_a,
    input  logic [DATA_W-1:0]         opnd_b,
    input  logic [$clog2(DATA_W)-1:0] sat_width,
    input  logic                      flag_clr,
    output logic [DATA_W-1:0]         result,
    output logic                      sat_flag
);

    localparam int NW     = $clog2(DATA_W);
    localparam int LANES  = 2;
    localparam int HALF_W = DATA_W / LANES;

    sat_op_e           op_e;
    logic [DATA_W-1:0] ar_res;
    logic              ar_sat;
    logic [DATA_W-1:0] wd_res;
    logic              wd_sat;
    logic [DATA_W-1:0] lane_res;
    logic [LANES-1:0]  lane_sat;
    logic [DATA_W-1:0] nxt_res;
    logic              nxt_sat;

    assign op_e = sat_op_e'(op_code);

    sat_arith #(.W(DATA_W)) i_arith (
        .op  (op_e),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (ar_res),
        .sat (ar_sat)
    );

    sat_clamp #(.W(DATA_W), .NW(NW)) i_word_clamp (
        .val       (opnd_a),
        .n         (sat_width),
        .is_signed (op_e == OP_SCLAMP),
        .res       (wd_res),
        .sat       (wd_sat)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sat_clamp #(.W(HALF_W), .NW(NW)) i_half_clamp (
            .val       (opnd_a[g*HALF_W +: HALF_W]),
            .n         (sat_width),
            .is_signed (op_e == OP_SCLAMP2),
            .res       (lane_res[g*HALF_W +: HALF_W]),
            .sat       (lane_sat[g])
        );
    end

    // Route the active operation's result and saturation.
    always_comb begin
        unique case (op_e)
            OP_SADD, OP_SSUB, OP_SDBL, OP_UADD, OP_USUB: begin
                nxt_res = ar_res;
                nxt_sat = ar_sat;
            end
            OP_SCLAMP, OP_UCLAMP: begin
                nxt_res = wd_res;
                nxt_sat = wd_sat;
            end
            OP_SCLAMP2, OP_UCLAMP2: begin
                nxt_res = lane_res;
                nxt_sat = |lane_sat;
            end
            default: begin
                nxt_res = '0;
                nxt_sat = 1'b0;
            end
        endcase
    end

    // Register the result.
    always_ff @(posedge clk) begin
        if (!rst_n) result <= '0;
        else        result <= nxt_res;
    end

    sat_sticky i_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (nxt_sat),
        .clr   (flag_clr),
        .flag  (sat_flag)
    );

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !sat_flag));

    a_r5_uadd_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd4 && ({1'b0, opnd_a} + {1'b0, opnd_b}) > {1'b0, {DATA_W{1'b1}}})
        |=> (result == {DATA_W{1'b1}} && sat_flag));

    a_r6_usub_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd5 && opnd_b > opnd_a) |=> (result == '0 && sat_flag));

    a_r12_idle_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_code == 4'd0 || op_code > 4'd9) && !flag_clr)
        |=> (result == '0 && $stable(sat_flag)));

    a_r2_sadd_positive: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd1 && !opnd_a[DATA_W-1] && !opnd_b[DATA_W-1])
        |=> !result[DATA_W-1]);

endmodule

// File: tb/test_sat_unit.sv
// Directed bench for sat_unit with a 64-bit reference model.
module test_sat_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  sat_width = '0;
    logic        flag_clr = 1'b0;
    logic [31:0] result;
    logic        sat_flag;

    int checks = 0;
    int fails  = 0;
    logic exp_flag = 1'b0;

    always #5 clk = ~clk;

    sat_unit i_sat_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_code   (op_code),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .sat_width (sat_width),
        .flag_clr  (flag_clr),
        .result    (result),
        .sat_flag  (sat_flag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic clamp_ref(input longint v, input int n, input bit sgn,
                             output longint r, output bit s);
        longint hi;
        longint lo;
        hi = (64'sd1 <<< n) - 1;
        lo = sgn ? -(64'sd1 <<< n) : 0;
        s = 1'b1;
        if (v > hi)      r = hi;
        else if (v < lo) r = lo;
        else begin r = v; s = 1'b0; end
    endtask

    task automatic ref_calc(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                            input int n, output logic [31:0] r, output bit s);
        longint x;
        longint y;
        longint t;
        bit     s1;
        bit     s2;
        s = 1'b0;
        r = '0;
        case (op)
            4'd1, 4'd2, 4'd3: begin
                x = longint'($signed(a));
                y = longint'($signed(b));
                if (op == 4'd1)      t = x + y;
                else if (op == 4'd2) t = x - y;
                else                 t = 2 * x;
                if (op == 4'd3 && x <= -(64'sd1 <<< 30)) begin
                    r = 32'h80000000; s = 1'b1;
                end else if (t > 64'sd2147483647) begin
                    r = 32'h7FFFFFFF; s = 1'b1;
                end else if (t < -64'sd2147483648) begin
                    r = 32'h80000000; s = 1'b1;
                end else r = t[31:0];
            end
            4'd4: begin
                t = longint'(a) + longint'(b);
                if (t > 64'sd4294967295) begin r = '1; s = 1'b1; end
                else r = t[31:0];
            end
            4'd5: begin
                if (b > a) begin r = '0; s = 1'b1; end
                else r = a - b;
            end
            4'd6, 4'd7: begin
                clamp_ref(longint'($signed(a)), n, op == 4'd6, t, s);
                r = t[31:0];
            end
            4'd8, 4'd9: begin
                clamp_ref(longint'($signed(a[15:0])), n, op == 4'd8, t, s1);
                r[15:0] = t[15:0];
                clamp_ref(longint'($signed(a[31:16])), n, op == 4'd8, t, s2);
                r[31:16] = t[15:0];
                s = s1 || s2;
            end
            default: begin r = '0; s = 1'b0; end
        endcase
    endtask

    // Drive one operation at a falling edge and check it one edge later.
    task automatic run_op(input string tag, input logic [3:0] op, input logic [31:0] a,
                          input logic [31:0] b, input int n, input logic clr);
        logic [31:0] er;
        bit          es;
        ref_calc(op, a, b, n, er, es);
        op_code = op; opnd_a = a; opnd_b = b; sat_width = 5'(n); flag_clr = clr;
        @(negedge clk);
        exp_flag = (exp_flag && !clr) || es;
        check({tag, " result"}, result, er);
        check({tag, " flag"}, {31'd0, sat_flag}, {31'd0, exp_flag});
        op_code = 4'd0; flag_clr = 1'b0;
    endtask

    task automatic clear_flag();
        run_op("R11", 4'd0, '0, '0, 0, 1'b1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        exp_flag = 1'b0;
        check("R1 result", result, '0);
        check("R1 flag", {31'd0, sat_flag}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_sadd();
        clear_flag();
        run_op("R2", 4'd1, 32'd5, 32'd3, 0, 1'b0);
        run_op("R2", 4'd1, 32'h7FFFFFFF, 32'h80000000, 0, 1'b0);
        run_op("R2", 4'd1, 32'h7FFFFFFF, 32'd1, 0, 1'b0);
        run_op("R2", 4'd1, 32'h80000000, 32'hFFFFFFFF, 0, 1'b0);
        run_op("R2", 4'd1, 32'h40000000, 32'h40000000, 0, 1'b0);
    endtask

    task automatic t_ssub();
        clear_flag();
        run_op("R3", 4'd2, 32'd16, 32'd32, 0, 1'b0);
        run_op("R3", 4'd2, 32'h80000000, 32'd1, 0, 1'b0);
        run_op("R3", 4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 1'b0);
        run_op("R3", 4'd2, 32'd0, 32'h80000000, 0, 1'b0);
    endtask

    task automatic t_sdbl();
        clear_flag();
        run_op("R4", 4'd3, 32'h3FFFFFFF, '0, 0, 1'b0);
        run_op("R4", 4'd3, 32'hC0000001, '0, 0, 1'b0);
        run_op("R4", 4'd3, 32'hFFFFFFFF, '0, 0, 1'b0);
        run_op("R4", 4'd3, 32'hC0000000, '0, 0, 1'b0);
        clear_flag();
        run_op("R4", 4'd3, 32'h40000000, '0, 0, 1'b0);
        run_op("R4", 4'd3, 32'h80000000, '0, 0, 1'b0);
    endtask

    task automatic t_unsigned();
        clear_flag();
        run_op("R5", 4'd4, 32'd16, 32'd32, 0, 1'b0);
        run_op("R5", 4'd4, 32'hFFFFFFFF, 32'd1, 0, 1'b0);
        run_op("R5", 4'd4, 32'h80000000, 32'h80000000, 0, 1'b0);
        clear_flag();
        run_op("R6", 4'd5, 32'd9, 32'd4, 0, 1'b0);
        run_op("R6", 4'd5, 32'd5, 32'd5, 0, 1'b0);
        run_op("R6", 4'd5, 32'd1, 32'd2, 0, 1'b0);
    endtask

    task automatic t_word_clamp(input string tag, input logic [3:0] op);
        for (int n = 0; n < 32; n++) begin
            logic [31:0] p;
            p = 32'd1 << n;
            clear_flag();
            run_op(tag, op, 32'd0, '0, n, 1'b0);
            run_op(tag, op, 32'd1, '0, n, 1'b0);
            run_op(tag, op, 32'hFFFFFFFF, '0, n, 1'b0);
            run_op(tag, op, p, '0, n, 1'b0);
            run_op(tag, op, p - 32'd1, '0, n, 1'b0);
            run_op(tag, op, -p, '0, n, 1'b0);
            run_op(tag, op, -p - 32'd1, '0, n, 1'b0);
            run_op(tag, op, 32'h7FFFFFFF, '0, n, 1'b0);
            run_op(tag, op, 32'h80000000, '0, n, 1'b0);
        end
    endtask

    task automatic t_dual();
        for (int n = 0; n < 32; n++) begin
            for (int k = 8; k <= 9; k++) begin
                clear_flag();
                run_op("R9", 4'(k), 32'h00030005, '0, n, 1'b0);
                run_op("R9", 4'(k), 32'h7FFF8000, '0, n, 1'b0);
                run_op("R9", 4'(k), 32'h0100FF00, '0, n, 1'b0);
                run_op("R9", 4'(k), 32'h0003FFFC, '0, n, 1'b0);
                run_op("R9", 4'(k), 32'hFFFF0000, '0, n, 1'b0);
            end
        end
    endtask

    task automatic t_sticky();
        clear_flag();
        run_op("R10", 4'd4, 32'd1, 32'd1, 0, 1'b0);
        run_op("R10", 4'd4, 32'hFFFFFFFF, 32'd2, 0, 1'b0);
        run_op("R10", 4'd1, 32'd1, 32'd1, 0, 1'b0);
        run_op("R10", 4'd7, 32'd3, '0, 4, 1'b0);
        check("R10 held", {31'd0, sat_flag}, 32'd1);
    endtask

    task automatic t_collide();
        clear_flag();
        run_op("R11", 4'd1, 32'd2, 32'd2, 0, 1'b1);
        run_op("R11", 4'd1, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 1'b0);
        run_op("R11", 4'd1, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 1'b1);
        check("R11 collide set", {31'd0, sat_flag}, 32'd1);
        run_op("R11", 4'd4, 32'd1, 32'd1, 0, 1'b1);
        check("R11 cleared", {31'd0, sat_flag}, 32'd0);
    endtask

    task automatic t_idle();
        run_op("R12", 4'd5, 32'd0, 32'd1, 0, 1'b0);
        run_op("R12", 4'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 1'b0);
        run_op("R12", 4'd10, 32'hFFFFFFFF, 32'd7, 3, 1'b0);
        run_op("R12", 4'd15, 32'h80000000, 32'h1, 0, 1'b0);
        clear_flag();
        run_op("R12", 4'd12, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 1'b0);
        run_op("R12", 4'd14, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 1'b0);
    endtask

    task automatic t_reset_mid();
        run_op("R1", 4'd5, 32'd0, 32'd9, 0, 1'b0);
        t_reset();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_sadd();
        t_ssub();
        t_sdbl();
        t_unsigned();
        t_word_clamp("R7", 4'd6);
        t_word_clamp("R8", 4'd7);
        t_dual();
        t_sticky();
        t_collide();
        t_idle();
        t_reset_mid();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule